// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block decides, for each commit slot of a multithreaded out-of-order core, which hardware thread may retire the instruction at the head of its reorder buffer. For every thread it sees four things: a commit state code, a flag saying the buffer head is ready, a flag saying the buffer is empty, and the head instruction's sequence number. For every commit slot it returns a grant flag and a thread number. A static two-bit input chooses one of three selection policies.

In round-robin mode the block keeps an ordering of the threads. Each grant moves the chosen thread to the tail of that ordering. Later slots in the same cycle see the updated ordering through a combinational chain, and the registered ordering takes the final result at the next clock edge. The oldest-first mode picks the thread whose ready head has the smallest sequence number, and it answers only the first slot of a cycle. The aggressive mode makes the same oldest-first choice but answers every slot that asks. When the block is built for a single thread, the policy plays no part.

Top module: `smt_commit_pick`

## Requirements
- R1: A thread can be granted only if its 3-bit state code is 0 (idle), 1 (running) or 4 (fetch-trap waiting). Codes 2 (buffer squashing), 3 (trap waiting), 5, 6 and 7 block it. In multi-thread builds a thread is a candidate only if its state allows a grant, its head-ready flag is 1 and its empty flag is 0.
- R2: Out of reset the round-robin ordering is thread 0, 1, 2, 3 (ascending). With every thread a candidate and both slots requesting, the first cycle grants thread 0 in slot 0 and thread 1 in slot 1.
- R3: With policy code 1 (round-robin), a requesting slot grants the first candidate in the ordering. That thread moves to the tail of the ordering, the threads behind it each move up one place, and the registered ordering holds the result after the clock edge.
- R4: In round-robin, slot k uses the ordering as slots 0 to k-1 of the same cycle have already changed it.
- R5: With policy code 2 (oldest-first), slot 0 grants the candidate with the smallest head sequence number. Sequence numbers are compared as unsigned values with no wraparound. When two numbers are equal, the lower thread number wins.
- R6: With policy code 2, every slot other than slot 0 gives no grant.
- R7: With policy code 0 (aggressive), every requesting slot grants the same thread that R5 would choose.
- R8: A slot with no grant drives its grant flag to 0 and its thread field to 0. This includes the case where no thread is a candidate.
- R9: A slot whose request bit is 0 gives no grant and leaves the round-robin ordering unchanged.
- R10: Policy code 3 gives no grants. Under any policy code other than 1, the round-robin ordering stays unchanged.
- R11: When built with one thread, a requesting slot grants thread 0 whenever its state code allows it (R1). This holds whatever the head-ready flag, empty flag and policy are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the round-robin ordering |
| policy_sel | input | 2 | 0 aggressive, 1 round-robin, 2 oldest-first, 3 no grants |
| slot_req | input | SLOTS | Per-slot request for a thread choice this cycle |
| thr_status | input | NTHR*3 | Per-thread commit state code, thread i at bits [3i+2:3i] |
| head_rdy | input | NTHR | Per-thread head instruction ready |
| rob_empty | input | NTHR | Per-thread reorder buffer empty |
| head_seq | input | NTHR*SEQW | Per-thread head sequence number, thread i at bits [SEQW*i +: SEQW] |
| grant_vld | output | SLOTS | Per-slot grant valid |
| grant_tid | output | SLOTS*TIDW | Per-slot granted thread, slot s at bits [TIDW*s +: TIDW] |

## Verification
The embedded assertions check these properties on every cycle:
- every granted thread carries a state code that allows a grant;
- no slot without a request is granted;
- later slots stay silent under oldest-first;
- no slot is granted when there is no candidate;
- the oldest-first winner has no older candidate and no equal-age candidate with a lower thread number;
- the round-robin ordering always stays a permutation and is frozen outside round-robin.

Only the bench scenarios can show the exact rotation order. That covers which thread moves to the tail, how the second slot sees the first slot's change, and how that carries across clock edges and policy switches. The same holds for the reset ordering and the single-thread build ignoring policy and readiness.

// File: rtl/smt_commit_pick.sv
module smt_commit_pick #(
  parameter int NTHR  = 4,
  parameter int SLOTS = 2,
  parameter int SEQW  = 16,
  localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             policy_sel,
  input  logic [SLOTS-1:0]       slot_req,
  input  logic [NTHR*3-1:0]      thr_status,
  input  logic [NTHR-1:0]        head_rdy,
  input  logic [NTHR-1:0]        rob_empty,
  input  logic [NTHR*SEQW-1:0]   head_seq,
  output logic [SLOTS-1:0]       grant_vld,
  output logic [SLOTS*TIDW-1:0]  grant_tid
);

  localparam logic [1:0] POL_AGG = 2'd0;
  localparam logic [1:0] POL_RR  = 2'd1;
  localparam logic [1:0] POL_OLD = 2'd2;

  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_RUN   = 3'd1;
  localparam logic [2:0] ST_FTRAP = 3'd4;

  logic [NTHR-1:0] elig, cand;

  for (genvar i = 0; i < NTHR; i++) begin : g_thr
    logic [2:0] st;
    assign st      = thr_status[i*3 +: 3];
    assign elig[i] = (st == ST_IDLE) | (st == ST_RUN) | (st == ST_FTRAP);
    assign cand[i] = elig[i] & head_rdy[i] & ~rob_empty[i];
  end

  logic            old_vld;
  logic [TIDW-1:0] old_tid;
  logic [SEQW-1:0] old_seq;

  always_comb begin
    old_vld = 1'b0;
    old_tid = '0;
    old_seq = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (cand[i] && (!old_vld || head_seq[i*SEQW +: SEQW] < old_seq)) begin
        old_vld = 1'b1;
        old_tid = TIDW'(i);
        old_seq = head_seq[i*SEQW +: SEQW];
      end
    end
  end

  logic [TIDW-1:0] order_q [NTHR];
  logic [TIDW-1:0] walk    [NTHR];
  logic            hit;
  int              pos;
  logic [TIDW-1:0] gtid;

  always_comb begin
    walk      = order_q;
    grant_vld = '0;
    grant_tid = '0;
    hit       = 1'b0;
    pos       = 0;
    gtid      = '0;
    for (int s = 0; s < SLOTS; s++) begin
      hit  = 1'b0;
      pos  = 0;
      gtid = '0;
      if (NTHR == 1) begin
        hit = slot_req[s] & elig[0];
      end else if (slot_req[s]) begin
        case (policy_sel)
          POL_AGG: begin
            hit  = old_vld;
            gtid = old_tid;
          end
          POL_OLD: begin
            if (s == 0) begin
              hit  = old_vld;
              gtid = old_tid;
            end
          end
          POL_RR: begin
            for (int p = 0; p < NTHR; p++) begin
              if (!hit && cand[walk[p]]) begin
                hit  = 1'b1;
                pos  = p;
                gtid = walk[p];
              end
            end
            if (hit) begin
              for (int p = 0; p < NTHR - 1; p++)
                if (p >= pos) walk[p] = walk[p+1];
              walk[NTHR-1] = gtid;
            end
          end
          default: ;
        endcase
      end
      grant_vld[s]              = hit;
      grant_tid[s*TIDW +: TIDW] = hit ? gtid : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) order_q[i] <= TIDW'(i);
    end else begin
      order_q <= walk;
    end
  end

  logic [NTHR*TIDW-1:0] order_flat;
  logic [NTHR-1:0]      seen;
  logic                 older_exists;
  logic [TIDW-1:0]      g0;
  logic [SEQW-1:0]      g0_seq;

  assign g0     = grant_tid[TIDW-1:0];
  assign g0_seq = head_seq[g0*SEQW +: SEQW];

  always_comb begin
    seen         = '0;
    older_exists = 1'b0;
    order_flat   = '0;
    for (int i = 0; i < NTHR; i++) begin
      order_flat[i*TIDW +: TIDW] = order_q[i];
      seen[order_q[i]]           = 1'b1;
      if (cand[i] && (head_seq[i*SEQW +: SEQW] < g0_seq ||
          (head_seq[i*SEQW +: SEQW] == g0_seq && TIDW'(i) < g0)))
        older_exists = 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    logic [2:0] gst;
    assign gst = thr_status[grant_tid[s*TIDW +: TIDW]*3 +: 3];

    // R1
    grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld[s] |-> (gst == 3'd0 || gst == 3'd1 || gst == 3'd4));

    // R9
    unreq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_req[s] |-> !grant_vld[s]);

    if (s > 0) begin : g_late
      // R6
      old_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (NTHR > 1 && policy_sel == POL_OLD) |-> !grant_vld[s]);
    end
  end

  // R3
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    &seen);

  // R10
  order_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    policy_sel != POL_RR |=> $stable(order_flat));

  // R5
  oldest_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NTHR > 1 && grant_vld[0] && (policy_sel == POL_AGG || policy_sel == POL_OLD))
      |-> !older_exists);

  // R8
  no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NTHR > 1 && cand == '0) |-> grant_vld == '0);

endmodule

// File: tb/test_smt_commit_pick.sv
module test_smt_commit_pick;
  localparam int CLK_P = 10;
  localparam int NT = 4;
  localparam int SL = 2;
  localparam int SW = 16;
  localparam int TW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        policy_sel = '0;
  logic [SL-1:0]     slot_req = '0;
  logic [NT*3-1:0]   thr_status = '0;
  logic [NT-1:0]     head_rdy = '0;
  logic [NT-1:0]     rob_empty = '0;
  logic [NT*SW-1:0]  head_seq = '0;
  logic [SL-1:0]     grant_vld;
  logic [SL*TW-1:0]  grant_tid;

  logic [1:0]  one_pol = '0;
  logic        one_req = 1'b0;
  logic [2:0]  one_st = '0;
  logic        one_rdy = 1'b0;
  logic        one_emp = 1'b0;
  logic [SW-1:0] one_seq = '0;
  logic        one_vld;
  logic        one_tid;

  always #(CLK_P/2) clk = ~clk;

  smt_commit_pick #(.NTHR(NT), .SLOTS(SL), .SEQW(SW)) i_smt_commit_pick (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .slot_req(slot_req),
    .thr_status(thr_status), .head_rdy(head_rdy), .rob_empty(rob_empty),
    .head_seq(head_seq), .grant_vld(grant_vld), .grant_tid(grant_tid));

  smt_commit_pick #(.NTHR(1), .SLOTS(1), .SEQW(SW)) i_one (
    .clk(clk), .rst_n(rst_n), .policy_sel(one_pol), .slot_req(one_req),
    .thr_status(one_st), .head_rdy(one_rdy), .rob_empty(one_emp),
    .head_seq(one_seq), .grant_vld(one_vld), .grant_tid(one_tid));

  int checks = 0;
  int errors = 0;
  int mlist [NT];
  int nlist [NT];
  bit ev [SL];
  int et [SL];
  string etag [SL];

  function automatic bit ok_state(input logic [2:0] c);
    return c == 3'd0 || c == 3'd1 || c == 3'd4;
  endfunction

  task automatic check(input string tag, input bit gv, input int gt,
                       input bit xv, input int xt);
    checks++;
    if (gv !== xv || gt != xt) begin
      errors++;
      $display("FAIL %s: got vld=%0d tid=%0d, expected vld=%0d tid=%0d",
               tag, gv, gt, xv, xt);
    end
  endtask

  task automatic model();
    bit cnd [NT];
    bit ov; int ot; int os; bit anyc;
    ov = 0; ot = 0; os = 0; anyc = 0;
    for (int i = 0; i < NT; i++) begin
      cnd[i] = ok_state(thr_status[i*3 +: 3]) && head_rdy[i] && !rob_empty[i];
      anyc |= cnd[i];
      if (cnd[i] && (!ov || int'(head_seq[i*SW +: SW]) < os)) begin
        ov = 1; ot = i; os = int'(head_seq[i*SW +: SW]);
      end
    end
    nlist = mlist;
    for (int s = 0; s < SL; s++) begin
      ev[s] = 0; et[s] = 0;
      if (!slot_req[s]) etag[s] = "R9";
      else if (policy_sel == 2'd3) etag[s] = "R10";
      else if (!anyc) etag[s] = "R8";
      else if (policy_sel == 2'd1) etag[s] = (s == 0) ? "R3" : "R4";
      else if (policy_sel == 2'd0) etag[s] = "R7";
      else etag[s] = (s == 0) ? "R5" : "R6";
      if (slot_req[s]) begin
        if (policy_sel == 2'd0 || (policy_sel == 2'd2 && s == 0)) begin
          ev[s] = ov; et[s] = ot;
        end else if (policy_sel == 2'd1) begin
          int p; p = -1;
          for (int q = NT - 1; q >= 0; q--) if (cnd[nlist[q]]) p = q;
          if (p >= 0) begin
            int g; g = nlist[p];
            ev[s] = 1; et[s] = g;
            for (int q = p; q < NT - 1; q++) nlist[q] = nlist[q+1];
            nlist[NT-1] = g;
          end
        end
      end
    end
  endtask

  task automatic step(input string force_tag);
    #1;
    model();
    for (int s = 0; s < SL; s++)
      check(force_tag == "" ? etag[s] : force_tag, grant_vld[s],
            int'(grant_tid[s*TW +: TW]), ev[s], et[s]);
    @(posedge clk);
    if (policy_sel == 2'd1) mlist = nlist;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got running, expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) mlist[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: reset ordering, all threads ready
    policy_sel = 2'd1; slot_req = 2'b11;
    thr_status = '0; head_rdy = '1; rob_empty = '0;
    step("R2");
    step("R3");

    // R1: each thread alone as possible candidate, each state code
    policy_sel = 2'd0; slot_req = 2'b01; head_rdy = '1;
    for (int t = 0; t < NT; t++) begin
      for (int c = 0; c < 8; c++) begin
        thr_status = {NT{3'd2}};
        thr_status[t*3 +: 3] = 3'(c);
        step("R1");
      end
    end

    // R5: equal sequence numbers resolve to the lower thread
    policy_sel = 2'd2; slot_req = 2'b11; thr_status = '0;
    head_seq = {16'd3, 16'd1, 16'd1, 16'd7};
    step("");

    // R3..R10 mixed sweep
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      policy_sel = (r < 4) ? 2'd1 : (r < 6) ? 2'd0 : (r < 8) ? 2'd2 : 2'd3;
      slot_req = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b11;
      for (int i = 0; i < NT; i++) begin
        int k;
        k = $urandom_range(0, 2);
        thr_status[i*3 +: 3] = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7))
                               : (k == 0) ? 3'd0 : (k == 1) ? 3'd1 : 3'd4;
        head_rdy[i]  = ($urandom_range(0, 3) != 0);
        rob_empty[i] = ($urandom_range(0, 4) == 0);
        head_seq[i*SW +: SW] = SW'($urandom_range(0, 7));
      end
      step("");
    end

    // R11: single-thread build ignores policy and readiness
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 4; p++) begin
        for (int m = 0; m < 8; m++) begin
          one_st = 3'(c); one_pol = 2'(p);
          one_rdy = m[0]; one_emp = m[1]; one_req = m[2];
          #1;
          check("R11", one_vld, int'(one_tid),
                one_req && ok_state(3'(c)), 0);
          @(negedge clk);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule